// File: doc/BRIEF.md
# Counter-Bit Reset PWM Generator

A single-channel pulse-width modulator that runs from a slow reference tick, such as a 32 kHz enable pulse presented in the fast system clock domain. An 8-bit counter moves forward by one on each tick. The counter has no period-compare register. Instead, a 2-bit prescaler field picks one counter bit, and the counter returns to zero as soon as that bit would become set. A prescaler of 0, 1, 2 or 3 therefore gives a period of 128, 64, 32 or 16 ticks. At a 32 kHz tick these periods are 250 Hz, 500 Hz, 1 kHz and 2 kHz. As the period gets shorter, fewer counter bits take part in the duty comparison.

Software reaches the block through two byte-wide registers. Address 0 is the control register: bit 7 is the enable and bits [1:0] are the prescaler. Address 1 holds the 7-bit duty value. The output is high while the counter bits below the selected reset bit are strictly less than the duty value. A duty change acts on the output at once. A prescaler change leaves the counter as it is. Because the two settings sit in separate registers, software has to choose the order in which it writes them.

Top module: `pwm_bitsel`

## Requirements
- R1: After the synchronous reset, both registers read 0x00, the counter is 0 and `pwm_out` is low.
- R2: The control register (address 0) reads back with the enable in bit 7 and the prescaler in bits [1:0]. Bits [6:2] always read 0; for example, writing 0xFF reads back as 0x83.
- R3: The duty register (address 1) holds 7 bits. Bit 7 of a write is dropped and always reads 0; writing 0xFF reads back as 0x7F.
- R4: The counter advances only on a cycle with `ref_tick` high. With prescaler p, the counter goes to 0 instead of to count+1 when bit (7-p) of count+1 is 1. The period is therefore 128, 64, 32 or 16 ticks for p = 0, 1, 2, 3, and over two periods the output is high for exactly 2 × duty ticks.
- R5: `pwm_out` is high exactly when the block is enabled and (count AND (2^(7-p) − 1)) is less than the duty value. A duty of 0 keeps the output low.
- R6: Any duty of 2^(7-p) or more holds the output constantly high. With p = 0 the largest duty is 127, which gives 127 high ticks in every 128.
- R7: While the enable is 0, the counter is held at 0 and the output is low. After re-enabling, counting restarts from 0.
- R8: Writing a new prescaler does not clear the counter. Counting continues from the present value under the new reset bit.
- R9: A duty write changes the output in the cycle right after the write edge, without waiting for the end of the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable pulse from the slow reference |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 duty |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the register selected by `reg_addr` |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach is a prescaler change at a moment when the counter is above the new period. At that point the counter has to run forward until the new reset bit would set, rather than restart at zero. The bench reaches this state by counting 40 ticks with prescaler 0 and then switching to prescaler 3. From there it follows a model of the counter, built from the requirements, tick by tick through the early wrap. The immediate duty update is checked by writing a new duty value in the middle of a period and sampling the output in the next cycle.

// File: rtl/pwm_bitsel_pkg.sv
package pwm_bitsel_pkg;

    localparam int CNT_W  = 8;
    localparam int PSC_W  = 2;
    localparam int DATA_W = 8;
    localparam int DUTY_W = CNT_W - 1;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_DUTY = 1'b1
    } pwm_sel_e;

    typedef struct packed {
        logic             en;
        logic [PSC_W-1:0] psc;
    } pwm_ctrl_t;

    // bits of the counter that take part in the duty comparison
    function automatic logic [CNT_W-1:0] active_mask(input logic [PSC_W-1:0] p);
        logic [CNT_W-1:0] m;
        m = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < CNT_W - 1 - int'(p)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwm_bitsel_regs.sv
module pwm_bitsel_regs
    import pwm_bitsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output pwm_ctrl_t         ctrl,
    output logic [DUTY_W-1:0] duty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            duty <= '0;
        end else if (we) begin
            if (pwm_sel_e'(addr) == SEL_CTRL) begin
                ctrl.en  <= wdata[DATA_W-1];
                ctrl.psc <= wdata[PSC_W-1:0];
            end else begin
                duty <= wdata[DUTY_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (pwm_sel_e'(addr) == SEL_CTRL) begin
            rdata[DATA_W-1]  = ctrl.en;
            rdata[PSC_W-1:0] = ctrl.psc;
        end else begin
            rdata[DUTY_W-1:0] = duty;
        end
    end

endmodule

// File: rtl/pwm_bitsel_counter.sv
module pwm_bitsel_counter
    import pwm_bitsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic [PSC_W-1:0] psc,
    output logic [CNT_W-1:0] cnt
);

    localparam int NUM_PSC = 1 << PSC_W;

    logic [CNT_W-1:0]   cnt_inc;
    logic [NUM_PSC-1:0] wrap_hit;

    assign cnt_inc = cnt + {{(CNT_W-1){1'b0}}, 1'b1};

    // one candidate reset bit per prescaler setting
    generate
        for (genvar g = 0; g < NUM_PSC; g++) begin : g_wrap
            assign wrap_hit[g] = cnt_inc[CNT_W-1-g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap_hit[psc] ? '0 : cnt_inc;
        end
    end

endmodule

// File: rtl/pwm_bitsel_compare.sv
module pwm_bitsel_compare
    import pwm_bitsel_pkg::*;
(
    input  logic              en,
    input  logic [PSC_W-1:0]  psc,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm
);

    logic [CNT_W-1:0] active;

    assign active = cnt & active_mask(psc);
    assign pwm    = en && (active < {1'b0, duty});

endmodule

// File: rtl/pwm_bitsel.sv
module pwm_bitsel
    import pwm_bitsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out
);

    pwm_ctrl_t         ctrl_q;
    logic [DUTY_W-1:0] duty_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              en_q;
    logic [PSC_W-1:0]  psc_q;

    assign en_q  = ctrl_q.en;
    assign psc_q = ctrl_q.psc;

    pwm_bitsel_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl_q),
        .duty  (duty_q)
    );

    pwm_bitsel_counter u_counter (
        .clk  (clk),
        .rst  (rst),
        .tick (ref_tick),
        .en   (en_q),
        .psc  (psc_q),
        .cnt  (cnt_q)
    );

    pwm_bitsel_compare u_compare (
        .en   (en_q),
        .psc  (psc_q),
        .cnt  (cnt_q),
        .duty (duty_q),
        .pwm  (pwm_out)
    );

endmodule

// File: rtl/pwm_bitsel_chk.sv
module pwm_bitsel_chk
    import pwm_bitsel_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              en,
    input logic [PSC_W-1:0]  psc,
    input logic [CNT_W-1:0]  cnt,
    input logic [DUTY_W-1:0] duty,
    input logic              addr,
    input logic [DATA_W-1:0] rdata,
    input logic              pwm
);

    logic [CNT_W-1:0] full_level;
    assign full_level = {{(CNT_W-1){1'b0}}, 1'b1} << (CNT_W - 1 - int'(psc));

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pwm);                                       // R7
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));                                 // R7
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(cnt));                      // R4
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !pwm);                               // R5
    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (rst)
        (en && ({1'b0, duty} >= full_level)) |-> pwm);        // R6
    AST_DUTY_MSB: assert property (@(posedge clk) disable iff (rst)
        addr |-> !rdata[DATA_W-1]);                           // R3
    AST_CTRL_PAD: assert property (@(posedge clk) disable iff (rst)
        !addr |-> (rdata[DATA_W-2:PSC_W] == '0));             // R2

endmodule

bind pwm_bitsel pwm_bitsel_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .tick  (ref_tick),
    .en    (en_q),
    .psc   (psc_q),
    .cnt   (cnt_q),
    .duty  (duty_q),
    .addr  (reg_addr),
    .rdata (reg_rdata),
    .pwm   (pwm_out)
);

// File: tb/test_pwm_bitsel.sv
module test_pwm_bitsel;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;

    // requirement-level model
    logic [7:0] m_cnt = 8'h00;
    logic       m_en = 1'b0;
    logic [1:0] m_p = 2'd0;
    logic [6:0] m_duty = 7'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bitsel i_pwm_bitsel (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic model_out();
        logic [7:0] mask;
        mask = 8'((1 << (7 - int'(m_p))) - 1);
        return m_en && ((m_cnt & mask) < {1'b0, m_duty});
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (!a) begin
            m_en = d[7]; m_p = d[1:0];
            if (!m_en) m_cnt = 8'h00;
        end else begin
            m_duty = d[6:0];
        end
    endtask

    task automatic read_check(input string req, input logic a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, "register read", 32'(reg_rdata), 32'(exp));
    endtask

    // one reference tick, then one idle cycle; output checked after each
    task automatic tick_once(input string req, inout int highs);
        logic [7:0] nxt;
        @(negedge clk);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
        if (m_en) begin
            nxt = m_cnt + 8'd1;
            m_cnt = nxt[7 - int'(m_p)] ? 8'h00 : nxt;
        end
        check(req, "output after tick", 32'(pwm_out), 32'(model_out()));
        if (pwm_out) highs++;
        @(negedge clk);
        check("R4", "output held without tick", 32'(pwm_out), 32'(model_out()));
    endtask

    task automatic run_ticks(input string req, input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) tick_once(req, highs);
    endtask

    task automatic t_reset();
        read_check("R1", 1'b0, 8'h00);
        read_check("R1", 1'b1, 8'h00);
        check("R1", "output after reset", 32'(pwm_out), 32'd0);
    endtask

    task automatic t_regs();
        write_reg(1'b0, 8'hFF);
        read_check("R2", 1'b0, 8'h83);
        write_reg(1'b1, 8'hFF);
        read_check("R3", 1'b1, 8'h7F);
        write_reg(1'b0, 8'h00);
        write_reg(1'b1, 8'h00);
        read_check("R2", 1'b0, 8'h00);
    endtask

    task automatic t_periods();
        int highs;
        for (int p = 0; p < 4; p++) begin
            int per;
            per = 128 >> p;
            write_reg(1'b1, 8'(per / 4));
            write_reg(1'b0, 8'h80 | 8'(p));
            run_ticks("R5", 2 * per, highs);
            check("R4", "high ticks over two periods", 32'(highs), 32'(per / 2));
            write_reg(1'b0, 8'h00);
        end
    endtask

    task automatic t_full();
        int highs;
        write_reg(1'b1, 8'd64);
        write_reg(1'b0, 8'h81);
        run_ticks("R6", 64, highs);
        check("R6", "duty at limit, p=1", 32'(highs), 32'd64);
        write_reg(1'b0, 8'h00);
        write_reg(1'b1, 8'd127);
        write_reg(1'b0, 8'h80);
        run_ticks("R6", 128, highs);
        check("R6", "duty 127, p=0", 32'(highs), 32'd127);
        write_reg(1'b0, 8'h00);
    endtask

    task automatic t_zero();
        int highs;
        write_reg(1'b1, 8'd0);
        write_reg(1'b0, 8'h82);
        run_ticks("R5", 40, highs);
        check("R5", "zero duty", 32'(highs), 32'd0);
        write_reg(1'b0, 8'h00);
    endtask

    task automatic t_disable();
        int highs;
        write_reg(1'b1, 8'd50);
        write_reg(1'b0, 8'h80);
        run_ticks("R5", 30, highs);
        write_reg(1'b0, 8'h00);
        check("R7", "output when disabled", 32'(pwm_out), 32'd0);
        run_ticks("R7", 5, highs);
        check("R7", "ticks while disabled", 32'(highs), 32'd0);
        write_reg(1'b1, 8'd1);
        write_reg(1'b0, 8'h80);
        check("R7", "restart from zero", 32'(pwm_out), 32'd1);
        highs = 0;
        tick_once("R7", highs);
        check("R7", "count one after restart", 32'(pwm_out), 32'd0);
        write_reg(1'b0, 8'h00);
    endtask

    task automatic t_psc_change();
        int highs;
        write_reg(1'b1, 8'd9);
        write_reg(1'b0, 8'h80);
        run_ticks("R8", 40, highs);
        write_reg(1'b0, 8'h83);
        check("R8", "count kept across prescaler change", 32'(pwm_out), 32'd1);
        run_ticks("R8", 20, highs);
        write_reg(1'b0, 8'h00);
    endtask

    task automatic t_duty_now();
        int highs;
        write_reg(1'b1, 8'd5);
        write_reg(1'b0, 8'h80);
        run_ticks("R9", 10, highs);
        check("R9", "before duty raise", 32'(pwm_out), 32'd0);
        write_reg(1'b1, 8'd20);
        check("R9", "after duty raise", 32'(pwm_out), 32'd1);
        write_reg(1'b1, 8'd3);
        check("R9", "after duty drop", 32'(pwm_out), 32'd0);
        write_reg(1'b0, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_periods();
        t_full();
        t_zero();
        t_disable();
        t_psc_change();
        t_duty_now();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule